// File: doc/BRIEF.md
# Coprocessor Instruction Decode Stage

This block sits in the decode stage of a 32-bit MIPS-style integer pipeline. It takes a fetched instruction word with the next-PC value of that fetch and sorts system-coprocessor (coprocessor 0) and geometry-coprocessor (coprocessor 2) instructions into a small set of operations. The operations are register moves in either direction, control-register moves, return-from-exception, geometry command dispatch and silent no-ops. Encodings that must fault become a reserved-instruction trap request. The trap request carries the cause value and the address of the faulting instruction.

The two coprocessors use the same move sub-opcodes with different meanings. The system coprocessor faults on its control moves, on a set of sub-function codes and on reads of some register indices. The geometry coprocessor accepts all four moves and forwards its command number. Branch-on-coprocessor encodings are not executed for either coprocessor. A combinational helper flags signed overflow of an addition or subtraction for the integer datapath. Every accepted instruction produces exactly one registered strobe one cycle later: either an operation or a trap.

Top module: `cop_decode_stage`

## Requirements
- R1: While reset is asserted, and until an instruction is accepted after its release, out_valid and trap_req are both 0.
- R2: For primary opcode 0x10 (bits 31:26) with bit 25 (rs bit 4) set, the sub-function in bits 4:0 selects the operation. Sub-function 0x10 gives out_op 3 (return-from-exception). Sub-functions 0x01, 0x02, 0x06 and 0x08 trap. Every other sub-function gives out_op 4 (no-op).
- R3: For primary opcode 0x10 with rs (bits 25:21) below 0x10, rs 0x00 gives out_op 1 (system read) and rs 0x04 gives out_op 2 (system write). rs 0x02 and 0x06 trap.
- R4: A system read whose rd (bits 15:11) is 0, 1, 2, 4 or 10 traps instead of giving out_op 1. A system write to those indices does not trap.
- R5: rs 0x08 and 0x0C give out_op 4 with no trap, for both primary opcode 0x10 and 0x12.
- R6: For primary opcode 0x12 with bit 25 set, out_op is 9 (geometry command) and out_cmd equals bits 5:0. For any other operation, out_cmd is 0.
- R7: For primary opcode 0x12 with rs below 0x10, rs 0x00, 0x02, 0x04 and 0x06 give out_op 5 (data read), 6 (control read), 7 (data write) and 8 (control write). Any other rs gives out_op 4. None of these trap.
- R8: On a trap, trap_cause is 0x28 (exception code 10 shifted left by two) and trap_epc is the accepted in_next_pc minus 4. out_op is 10 during a trap.
- R9: In_valid high in a cycle gives exactly one of out_valid and trap_req high in the next cycle. In_valid low gives neither.
- R10: For each accepted instruction, out_rt carries bits 20:16 and out_rd carries bits 15:11.
- R11: With ar_sub 0, ar_res is ar_a + ar_b and ar_ovf is bit 31 of (a XOR NOT b) AND (a XOR result).
- R12: With ar_sub 1, ar_res is ar_a - ar_b and ar_ovf is bit 31 of (a XOR b) AND (a XOR result).
- R13: Any other primary opcode gives out_op 0 (not a coprocessor instruction) with no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction presented this cycle |
| in_insn | input | 32 | Instruction word |
| in_next_pc | input | 32 | Next-PC value belonging to the instruction |
| ar_a | input | 32 | Overflow helper first operand |
| ar_b | input | 32 | Overflow helper second operand |
| ar_sub | input | 1 | 1 selects subtraction, 0 addition |
| ar_res | output | 32 | Helper sum or difference |
| ar_ovf | output | 1 | Signed overflow of the helper result |
| out_valid | output | 1 | Decoded operation strobe |
| out_op | output | 4 | Operation code |
| out_rt | output | 5 | General register index |
| out_rd | output | 5 | Coprocessor register index |
| out_cmd | output | 6 | Geometry command number |
| trap_req | output | 1 | Reserved-instruction trap request |
| trap_cause | output | 8 | Trap cause value |
| trap_epc | output | 32 | Address of the faulting instruction |

## Verification
Every decode result is due one cycle after the clock edge that samples in_valid: out_valid, trap_req, out_op, the indices, out_cmd and the trap fields. The overflow helper is combinational and settles within the same cycle as its operands. The bench drives each instruction on a falling edge, lets one rising edge capture it, and samples on the following falling edge after dropping in_valid. The outputs therefore reflect that instruction alone. The helper is sampled a few time units after its operands change, with no clock edge in between.

// File: rtl/cdec_pkg.sv
package cdec_pkg;

  typedef enum logic [3:0] {
    OP_OTHER = 4'd0,
    OP_SYS_RD = 4'd1,
    OP_SYS_WR = 4'd2,
    OP_RFE = 4'd3,
    OP_NOP = 4'd4,
    OP_GEO_DRD = 4'd5,
    OP_GEO_CRD = 4'd6,
    OP_GEO_DWR = 4'd7,
    OP_GEO_CWR = 4'd8,
    OP_GEO_CMD = 4'd9,
    OP_TRAP = 4'd10
  } cdec_op_e;

  localparam logic [5:0] PRI_SYS = 6'h10;
  localparam logic [5:0] PRI_GEO = 6'h12;

endpackage

// File: rtl/cdec_sys_class.sv
module cdec_sys_class
  import cdec_pkg::*;
#(
  parameter logic [31:0] RD_FAULT_MASK = 32'h0000_0417
) (
  input  logic [4:0] rs,
  input  logic [4:0] rd,
  input  logic [4:0] sub_fn,
  output cdec_op_e   op,
  output logic       trap
);

  cdec_op_e op_raw;
  logic     trap_raw;

  always_comb begin
    op_raw   = OP_NOP;
    trap_raw = 1'b0;
    if (rs[4]) begin
      unique case (sub_fn)
        5'h10:                     op_raw = OP_RFE;
        5'h01, 5'h02, 5'h06, 5'h08: trap_raw = 1'b1;
        default:                   op_raw = OP_NOP;
      endcase
    end else begin
      unique case (rs)
        5'h00: begin
          if (RD_FAULT_MASK[rd]) trap_raw = 1'b1;
          else                   op_raw = OP_SYS_RD;
        end
        5'h04:        op_raw = OP_SYS_WR;
        5'h02, 5'h06: trap_raw = 1'b1;
        default:      op_raw = OP_NOP;
      endcase
    end
  end

  assign op   = trap_raw ? OP_TRAP : op_raw;
  assign trap = trap_raw;

endmodule

// File: rtl/cdec_geo_class.sv
module cdec_geo_class
  import cdec_pkg::*;
#(
  parameter int CMD_W = 6
) (
  input  logic [4:0]       rs,
  input  logic [CMD_W-1:0] fn,
  output cdec_op_e         op,
  output logic [CMD_W-1:0] cmd
);

  always_comb begin
    op  = OP_NOP;
    cmd = '0;
    if (rs[4]) begin
      op  = OP_GEO_CMD;
      cmd = fn;
    end else begin
      unique case (rs)
        5'h00:   op = OP_GEO_DRD;
        5'h02:   op = OP_GEO_CRD;
        5'h04:   op = OP_GEO_DWR;
        5'h06:   op = OP_GEO_CWR;
        default: op = OP_NOP;
      endcase
    end
  end

endmodule

// File: rtl/cdec_ovf.sv
module cdec_ovf #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            sub,
  output logic [XLEN-1:0] res,
  output logic            ovf
);

  localparam int MSB = XLEN - 1;

  logic [XLEN-1:0] sign_terms;

  always_comb begin
    if (sub) begin
      res        = a - b;
      sign_terms = (a ^ b) & (a ^ res);
    end else begin
      res        = a + b;
      sign_terms = (a ^ ~b) & (a ^ res);
    end
  end

  assign ovf = sign_terms[MSB];

  logic unused_terms;
  assign unused_terms = ^sign_terms[MSB-1:0];

endmodule

// File: rtl/cop_decode_stage.sv
module cop_decode_stage
  import cdec_pkg::*;
#(
  parameter int          XLEN          = 32,
  parameter int          RI_CODE       = 10,
  parameter int          CAUSE_W       = 8,
  parameter int          SYNC_STAGES   = 2,
  parameter logic [31:0] RD_FAULT_MASK = 32'h0000_0417
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [31:0]        in_insn,
  input  logic [XLEN-1:0]    in_next_pc,
  input  logic [XLEN-1:0]    ar_a,
  input  logic [XLEN-1:0]    ar_b,
  input  logic               ar_sub,
  output logic [XLEN-1:0]    ar_res,
  output logic               ar_ovf,
  output logic               out_valid,
  output logic [3:0]         out_op,
  output logic [4:0]         out_rt,
  output logic [4:0]         out_rd,
  output logic [5:0]         out_cmd,
  output logic               trap_req,
  output logic [CAUSE_W-1:0] trap_cause,
  output logic [XLEN-1:0]    trap_epc
);

  localparam int               CMD_W     = 6;
  localparam logic [CAUSE_W-1:0] CAUSE_VAL = CAUSE_W'(RI_CODE << 2);
  localparam logic [XLEN-1:0]  INSN_BYTES = XLEN'(4);

  // reset: asserted asynchronously, released through a flop chain
  logic [SYNC_STAGES-1:0] rst_chain;
  logic                   rst_q;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_rst_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rst_chain[gi] <= 1'b0;
        end else begin
          if (gi == 0) rst_chain[gi] <= 1'b1;
          else         rst_chain[gi] <= rst_chain[(gi == 0) ? 0 : gi-1];
        end
      end
    end
  endgenerate

  assign rst_q = rst_chain[SYNC_STAGES-1];

  // field split
  logic [5:0]       f_pri;
  logic [4:0]       f_rs;
  logic [4:0]       f_rt;
  logic [4:0]       f_rd;
  logic [CMD_W-1:0] f_fn;

  assign f_pri = in_insn[31:26];
  assign f_rs  = in_insn[25:21];
  assign f_rt  = in_insn[20:16];
  assign f_rd  = in_insn[15:11];
  assign f_fn  = in_insn[5:0];

  logic unused_shamt;
  assign unused_shamt = ^in_insn[10:6];

  // classifiers
  cdec_op_e         sys_op;
  logic             sys_trap;
  cdec_op_e         geo_op;
  logic [CMD_W-1:0] geo_cmd;

  cdec_sys_class #(
    .RD_FAULT_MASK(RD_FAULT_MASK)
  ) u_sys (
    .rs    (f_rs),
    .rd    (f_rd),
    .sub_fn(f_fn[4:0]),
    .op    (sys_op),
    .trap  (sys_trap)
  );

  cdec_geo_class #(
    .CMD_W(CMD_W)
  ) u_geo (
    .rs (f_rs),
    .fn (f_fn),
    .op (geo_op),
    .cmd(geo_cmd)
  );

  cdec_ovf #(
    .XLEN(XLEN)
  ) u_ovf (
    .a  (ar_a),
    .b  (ar_b),
    .sub(ar_sub),
    .res(ar_res),
    .ovf(ar_ovf)
  );

  // next-state selection
  cdec_op_e         dec_op;
  logic             dec_trap;
  logic [CMD_W-1:0] dec_cmd;
  logic [XLEN-1:0]  dec_epc;

  always_comb begin
    dec_op   = OP_OTHER;
    dec_trap = 1'b0;
    dec_cmd  = '0;
    if (f_pri == PRI_SYS) begin
      dec_op   = sys_op;
      dec_trap = sys_trap;
    end else if (f_pri == PRI_GEO) begin
      dec_op  = geo_op;
      dec_cmd = geo_cmd;
    end
  end

  assign dec_epc = in_next_pc - INSN_BYTES;

  logic valid_nxt;
  logic trap_nxt;

  assign valid_nxt = in_valid & ~dec_trap;
  assign trap_nxt  = in_valid & dec_trap;

  // strobe registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_valid <= 1'b0;
      trap_req  <= 1'b0;
    end else begin
      out_valid <= valid_nxt;
      trap_req  <= trap_nxt;
    end
  end

  // payload registers, loaded on accept
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_op     <= 4'(OP_OTHER);
      out_rt     <= '0;
      out_rd     <= '0;
      out_cmd    <= '0;
      trap_cause <= '0;
      trap_epc   <= '0;
    end else if (in_valid) begin
      out_op     <= 4'(dec_op);
      out_rt     <= f_rt;
      out_rd     <= f_rd;
      out_cmd    <= dec_cmd;
      trap_cause <= dec_trap ? CAUSE_VAL : '0;
      trap_epc   <= dec_epc;
    end
  end

endmodule

// File: rtl/cop_decode_stage_chk.sv
module cop_decode_stage_chk #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [31:0]        in_insn,
  input logic [XLEN-1:0]    in_next_pc,
  input logic [XLEN-1:0]    ar_a,
  input logic [XLEN-1:0]    ar_b,
  input logic               ar_sub,
  input logic [XLEN-1:0]    ar_res,
  input logic               ar_ovf,
  input logic               out_valid,
  input logic [3:0]         out_op,
  input logic [5:0]         out_cmd,
  input logic               trap_req,
  input logic [CAUSE_W-1:0] trap_cause,
  input logic [XLEN-1:0]    trap_epc
);

  localparam int MSB = XLEN - 1;

  logic unused_fields;
  assign unused_fields = ^in_insn[20:16] ^ ^in_insn[10:6];

  logic is_sys, is_geo;
  assign is_sys = in_insn[31:26] == 6'h10;
  assign is_geo = in_insn[31:26] == 6'h12;

  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_valid ^ trap_req));

  p_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !trap_req));

  p_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (trap_cause == CAUSE_W'(8'h28)));

  p_epc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid ##1 trap_req |-> (trap_epc == $past(in_next_pc) - XLEN'(4)));

  p_rfe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_sys && in_insn[25] && in_insn[4:0] == 5'h10)
    |=> (out_valid && out_op == 4'd3));

  p_rd_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_sys && in_insn[25:21] == 5'h00 &&
     (in_insn[15:11] == 5'd0 || in_insn[15:11] == 5'd1 || in_insn[15:11] == 5'd2 ||
      in_insn[15:11] == 5'd4 || in_insn[15:11] == 5'd10))
    |=> trap_req);

  p_geo_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_geo && in_insn[25])
    |=> (out_valid && out_op == 4'd9 && out_cmd == $past(in_insn[5:0])));

  p_geo_notrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_geo) |=> !trap_req);

  p_add_ovf_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ar_sub |-> (ar_ovf == ((ar_a[MSB] == ar_b[MSB]) && (ar_res[MSB] != ar_a[MSB]))));

  p_sub_ovf_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ar_sub |-> (ar_ovf == ((ar_a[MSB] != ar_b[MSB]) && (ar_res[MSB] != ar_a[MSB]))));

endmodule

bind cop_decode_stage cop_decode_stage_chk #(
  .XLEN   (XLEN),
  .CAUSE_W(CAUSE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .in_valid  (in_valid),
  .in_insn   (in_insn),
  .in_next_pc(in_next_pc),
  .ar_a      (ar_a),
  .ar_b      (ar_b),
  .ar_sub    (ar_sub),
  .ar_res    (ar_res),
  .ar_ovf    (ar_ovf),
  .out_valid (out_valid),
  .out_op    (out_op),
  .out_cmd   (out_cmd),
  .trap_req  (trap_req),
  .trap_cause(trap_cause),
  .trap_epc  (trap_epc)
);

// File: tb/cop_decode_stage_bench.sv
`timescale 1ns/1ps
module cop_decode_stage_bench;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_insn;
  logic [31:0] in_next_pc;
  logic [31:0] ar_a, ar_b;
  logic        ar_sub;
  logic [31:0] ar_res;
  logic        ar_ovf;
  logic        out_valid;
  logic [3:0]  out_op;
  logic [4:0]  out_rt, out_rd;
  logic [5:0]  out_cmd;
  logic        trap_req;
  logic [7:0]  trap_cause;
  logic [31:0] trap_epc;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  cop_decode_stage u_cop_decode_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
    .in_next_pc(in_next_pc), .ar_a(ar_a), .ar_b(ar_b), .ar_sub(ar_sub),
    .ar_res(ar_res), .ar_ovf(ar_ovf), .out_valid(out_valid), .out_op(out_op),
    .out_rt(out_rt), .out_rd(out_rd), .out_cmd(out_cmd), .trap_req(trap_req),
    .trap_cause(trap_cause), .trap_epc(trap_epc)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] mk(int pri, int rs, int rt, int rd, int fn);
    logic [5:0] p = pri[5:0];
    logic [4:0] s = rs[4:0];
    logic [4:0] t = rt[4:0];
    logic [4:0] d = rd[4:0];
    logic [5:0] f = fn[5:0];
    return {p, s, t, d, 5'd0, f};
  endfunction

  typedef struct packed {
    logic [31:0] insn;
    logic [3:0]  op;
    logic        trap;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VEC [NV] = '{
    // R2: system coprocessor, rs bit 4 set
    '{mk('h10,'h10,0,0,'h10), 4'd3, 1'b0, 4'd2},
    '{mk('h10,'h10,0,0,'h01), 4'd10, 1'b1, 4'd2},
    '{mk('h10,'h10,0,0,'h02), 4'd10, 1'b1, 4'd2},
    '{mk('h10,'h10,0,0,'h06), 4'd10, 1'b1, 4'd2},
    '{mk('h10,'h10,0,0,'h08), 4'd10, 1'b1, 4'd2},
    '{mk('h10,'h10,0,0,'h18), 4'd4, 1'b0, 4'd2},
    '{mk('h10,'h10,0,0,'h00), 4'd4, 1'b0, 4'd2},
    '{mk('h10,'h1F,2,3,'h1F), 4'd4, 1'b0, 4'd2},
    // R3: system moves
    '{mk('h10,'h00,5,12,0), 4'd1, 1'b0, 4'd3},
    '{mk('h10,'h04,5,3,0), 4'd2, 1'b0, 4'd3},
    '{mk('h10,'h02,5,3,0), 4'd10, 1'b1, 4'd3},
    '{mk('h10,'h06,5,3,0), 4'd10, 1'b1, 4'd3},
    // R4: faulting read indices
    '{mk('h10,'h00,1,0,0), 4'd10, 1'b1, 4'd4},
    '{mk('h10,'h00,1,1,0), 4'd10, 1'b1, 4'd4},
    '{mk('h10,'h00,1,2,0), 4'd10, 1'b1, 4'd4},
    '{mk('h10,'h00,1,4,0), 4'd10, 1'b1, 4'd4},
    '{mk('h10,'h00,1,10,0), 4'd10, 1'b1, 4'd4},
    '{mk('h10,'h00,1,3,0), 4'd1, 1'b0, 4'd4},
    '{mk('h10,'h00,1,11,0), 4'd1, 1'b0, 4'd4},
    '{mk('h10,'h04,1,0,0), 4'd2, 1'b0, 4'd4},
    // R5: branch-on-coprocessor encodings
    '{mk('h10,'h08,1,2,0), 4'd4, 1'b0, 4'd5},
    '{mk('h10,'h0C,1,2,0), 4'd4, 1'b0, 4'd5},
    '{mk('h12,'h08,1,2,0), 4'd4, 1'b0, 4'd5},
    '{mk('h12,'h0C,1,2,0), 4'd4, 1'b0, 4'd5},
    // R6: geometry commands
    '{mk('h12,'h10,0,0,'h06), 4'd9, 1'b0, 4'd6},
    '{mk('h12,'h1F,3,7,'h3F), 4'd9, 1'b0, 4'd6},
    // R7: geometry moves
    '{mk('h12,'h00,7,9,0), 4'd5, 1'b0, 4'd7},
    '{mk('h12,'h02,7,9,0), 4'd6, 1'b0, 4'd7},
    '{mk('h12,'h04,7,0,0), 4'd7, 1'b0, 4'd7},
    '{mk('h12,'h06,7,1,0), 4'd8, 1'b0, 4'd7},
    '{mk('h12,'h01,7,1,0), 4'd4, 1'b0, 4'd7},
    // R13: other primary opcodes
    '{mk('h08,'h00,4,5,'h10), 4'd0, 1'b0, 4'd13},
    '{mk('h11,'h10,4,5,'h10), 4'd0, 1'b0, 4'd13}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] insn, input logic [31:0] npc);
    @(negedge clk);
    in_valid   = 1'b1;
    in_insn    = insn;
    in_next_pc = npc;
    @(negedge clk);
    in_valid = 1'b0;
    #0.5;
  endtask

  task automatic ovf_case(input string req, input logic [31:0] a, input logic [31:0] b,
                          input logic sub, input logic [31:0] exp_res, input logic exp_ovf);
    ar_a = a; ar_b = b; ar_sub = sub;
    #1;
    chk({req, " result"}, ar_res, exp_res);
    chk({req, " overflow"}, 32'(ar_ovf), 32'(exp_ovf));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_insn = '0; in_next_pc = '0;
    ar_a = '0; ar_b = '0; ar_sub = 1'b0;
    repeat (3) @(negedge clk);
    // R1: strobes low in reset
    chk("R1 valid in reset", 32'(out_valid), 32'd0);
    chk("R1 trap in reset", 32'(trap_req), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 valid after release", 32'(out_valid), 32'd0);
    chk("R1 trap after release", 32'(trap_req), 32'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [31:0] npc;
      logic [5:0]  exp_cmd;
      string       tag;
      npc = 32'h8000_1000 + 32'(i * 16);
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      issue(VEC[i].insn, npc);
      chk({tag, " R9 valid"}, 32'(out_valid), 32'(!VEC[i].trap));
      chk({tag, " R9 trap"}, 32'(trap_req), 32'(VEC[i].trap));
      chk({tag, " op"}, 32'(out_op), 32'(VEC[i].op));
      if (VEC[i].trap) begin
        chk({tag, " R8 cause"}, 32'(trap_cause), 32'h28);
        chk({tag, " R8 epc"}, trap_epc, npc - 32'd4);
      end else begin
        exp_cmd = (VEC[i].op == 4'd9) ? VEC[i].insn[5:0] : 6'd0;
        chk({tag, " R6 cmd"}, 32'(out_cmd), 32'(exp_cmd));
        chk({tag, " R10 rt"}, 32'(out_rt), 32'(VEC[i].insn[20:16]));
        chk({tag, " R10 rd"}, 32'(out_rd), 32'(VEC[i].insn[15:11]));
      end
    end

    // R9: idle cycle produces no strobe
    @(negedge clk);
    chk("R9 idle valid", 32'(out_valid), 32'd0);
    chk("R9 idle trap", 32'(trap_req), 32'd0);

    // R8 / R9: back-to-back, trap then move
    @(negedge clk);
    in_valid = 1'b1; in_insn = mk('h10, 'h02, 0, 0, 0); in_next_pc = 32'h0000_0004;
    @(negedge clk);
    chk("R8 b2b trap", 32'(trap_req), 32'd1);
    chk("R8 b2b epc low", trap_epc, 32'h0000_0000);
    in_insn = mk('h12, 'h10, 0, 0, 'h2A); in_next_pc = 32'h0000_0100;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 b2b second valid", 32'(out_valid), 32'd1);
    chk("R9 b2b second trap", 32'(trap_req), 32'd0);
    chk("R6 b2b cmd", 32'(out_cmd), 32'h2A);

    // R8: epc wraps below zero
    issue(mk('h10, 'h10, 0, 0, 'h08), 32'h0000_0000);
    chk("R8 epc wrap", trap_epc, 32'hFFFF_FFFC);

    // R11 / R12: overflow helper
    ovf_case("R11 pos wrap", 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 32'h8000_0000, 1'b1);
    ovf_case("R11 neg wrap", 32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 32'h7FFF_FFFF, 1'b1);
    ovf_case("R11 plain", 32'h0000_0001, 32'h0000_0002, 1'b0, 32'h0000_0003, 1'b0);
    ovf_case("R11 mixed sign", 32'h7FFF_FFFF, 32'h8000_0000, 1'b0, 32'hFFFF_FFFF, 1'b0);
    ovf_case("R12 neg wrap", 32'h8000_0000, 32'h0000_0001, 1'b1, 32'h7FFF_FFFF, 1'b1);
    ovf_case("R12 pos wrap", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, 32'h8000_0000, 1'b1);
    ovf_case("R12 plain", 32'h0000_0005, 32'h0000_0003, 1'b1, 32'h0000_0002, 1'b0);
    ovf_case("R12 same sign", 32'h8000_0000, 32'h8000_0000, 1'b1, 32'h0000_0000, 1'b0);

    // R1: reset mid-stream clears strobe
    @(negedge clk);
    in_valid = 1'b1; in_insn = mk('h10, 'h04, 1, 1, 0);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    #0.5;
    chk("R1 async clear", 32'(out_valid), 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule